// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside the write port of a byte-wide parallel flash array and watches every write bus cycle it is given. It recognises the multi-cycle command sequences that all begin with the same two-cycle unlock pair. For each completed sequence it produces a one-clock pulse on a dedicated output. The recognised commands are byte program, chip erase, boot-area lockout enable, identification entry and identification exit. A byte-program pulse comes with the target address and data latched from the last cycle.

The decoder also keeps the identification-mode flag, which entry sets and exit clears. It supplies the identification byte that a read returns in that mode, selected by the lowest read address bit. Carrying out the program, erase or lockout operation is left to the logic that consumes the pulses.

A write cycle is one clock with `wr_valid` high, carrying a full address and a data byte. The unlock addresses are matched on the low address bits only. Any cycle that breaks a sequence sends the machine back to idle, and that cycle does not start a new sequence.

Top module: `fcd_cmd_decoder`

## Requirements
- R1: After reset all pulse outputs are low, `id_mode` is low, and `prog_addr` and `prog_data` are zero.
- R2: The cycles 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 followed by any data D at any address A make `prog_pulse` high for one clock, starting on the clock after the fourth accepted cycle. At that time `prog_addr`=A (all address bits) and `prog_data`=D. The data cycle is taken as program data even when D is 0xF0.
- R3: The unlock pair, 0x80@0x5555, the unlock pair again, then 0x10@0x5555 make `erase_pulse` high for one clock.
- R4: The same five-cycle prefix as R3 followed by 0x40@0x5555 makes `lock_pulse` high for one clock.
- R5: The unlock pair followed by 0x90@0x5555 makes `id_enter_pulse` high for one clock and sets `id_mode` in the same clock.
- R6: A cycle with data 0xF0 makes `id_exit_pulse` high for one clock and clears `id_mode`. The address may be anything, and the cycle may be the third cycle after the unlock pair or may arrive in any other state except the program-data state.
- R7: Only address bits 14..0 are compared with 0x5555 and 0x2AAA, so bits above bit 14 do not affect a match.
- R8: A cycle that does not continue the current sequence returns the decoder to idle with no pulse, and that cycle does not itself start a new sequence. A clock without `wr_valid` changes nothing.
- R9: While `busy` is high, a write cycle is ignored: no pulse results and the sequence state is kept.
- R10: At most one pulse output is high in any clock.
- R11: `id_byte` is 0x1F when `rd_a0`=0. When `rd_a0`=1 it is 0x23 with `TOP_BOOT`=0 and 0x27 with `TOP_BOOT`=1.
- R12: `prog_addr` and `prog_data` hold their values until the next byte-program pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One write bus cycle this clock |
| wr_addr | input | ADDR_W (20) | Write address |
| wr_data | input | DATA_W (8) | Write data byte |
| busy | input | 1 | When high, write cycles are ignored |
| rd_a0 | input | 1 | Lowest read address bit, selects identification byte |
| prog_pulse | output | 1 | Byte program command |
| prog_addr | output | ADDR_W (20) | Latched program address |
| prog_data | output | DATA_W (8) | Latched program data |
| erase_pulse | output | 1 | Chip erase command |
| lock_pulse | output | 1 | Boot-area lockout enable command |
| id_enter_pulse | output | 1 | Identification entry command |
| id_exit_pulse | output | 1 | Identification exit command |
| id_mode | output | 1 | Identification mode flag |
| id_byte | output | DATA_W (8) | Identification byte for the current `rd_a0` |

## Verification
The bench builds the decoder with `TOP_BOOT`=1, a 20-bit address and a 15-bit compare width. Because of the top-boot setting, the device byte 0x27 is visible through `id_byte`. The full 20-bit address lets directed and random cycles set bits 19..15 on the unlock addresses, so the masking of the upper bits can be exercised and program addresses above the compare window are checked in full. Random traffic is weighted toward the command bytes and unlock addresses, so nested aborts, busy-masked cycles and stray 0xF0 exits all occur within a few thousand clocks.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PROG,
        ST_ERA1,
        ST_ERA2,
        ST_ERA3
    } seq_state_e;

    localparam int NCODE   = 8;
    localparam int C_KEY1  = 0;
    localparam int C_KEY2  = 1;
    localparam int C_PROG  = 2;
    localparam int C_PRE   = 3;
    localparam int C_ERASE = 4;
    localparam int C_LOCK  = 5;
    localparam int C_IDIN  = 6;
    localparam int C_IDOUT = 7;

    localparam logic [14:0] KEY1_ADDR = 15'h5555;
    localparam logic [14:0] KEY2_ADDR = 15'h2AAA;

    localparam logic [7:0] ID_MFR     = 8'h1F;
    localparam logic [7:0] ID_DEV_BOT = 8'h23;
    localparam logic [7:0] ID_DEV_TOP = 8'h27;

    function automatic logic [7:0] code_of(input int idx);
        logic [7:0] c;
        case (idx)
            C_KEY1:  c = 8'hAA;
            C_KEY2:  c = 8'h55;
            C_PROG:  c = 8'hA0;
            C_PRE:   c = 8'h80;
            C_ERASE: c = 8'h10;
            C_LOCK:  c = 8'h40;
            C_IDIN:  c = 8'h90;
            default: c = 8'hF0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fcd_cycle_class.sv
module fcd_cycle_class
    import fcd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CMP_W  = 15
) (
    input  logic [CMP_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] data,
    output logic              at_key1,
    output logic              at_key2,
    output logic [NCODE-1:0]  dhit
);
    assign at_key1 = (addr_lo == CMP_W'(KEY1_ADDR));
    assign at_key2 = (addr_lo == CMP_W'(KEY2_ADDR));

    for (genvar i = 0; i < NCODE; i++) begin : g_code
        assign dhit[i] = (data == DATA_W'(code_of(i)));
    end
endmodule

// File: rtl/fcd_id_code.sv
module fcd_id_code
    import fcd_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              sel,
    output logic [DATA_W-1:0] code
);
    logic [DATA_W-1:0] dev_code;

    if (TOP_BOOT) begin : g_top
        assign dev_code = DATA_W'(ID_DEV_TOP);
    end else begin : g_bot
        assign dev_code = DATA_W'(ID_DEV_BOT);
    end

    assign code = sel ? dev_code : DATA_W'(ID_MFR);
endmodule

// File: rtl/fcd_cmd_decoder.sv
module fcd_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 8,
    parameter int CMP_W    = 15,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              rd_a0,
    output logic              prog_pulse,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_pulse,
    output logic              lock_pulse,
    output logic              id_enter_pulse,
    output logic              id_exit_pulse,
    output logic              id_mode,
    output logic [DATA_W-1:0] id_byte
);
    localparam int NPULSE = 5;

    typedef struct packed {
        seq_state_e        st;
        logic              prog;
        logic              erase;
        logic              lock;
        logic              enter;
        logic              leave;
        logic              id_mode;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic             at_key1, at_key2;
    logic [NCODE-1:0] dhit;
    logic             accept;
    logic             k1_cyc, k2_cyc;
    logic [NPULSE-1:0] pulse_vec;

    fcd_cycle_class #(
        .DATA_W (DATA_W),
        .CMP_W  (CMP_W)
    ) class_i (
        .addr_lo (wr_addr[CMP_W-1:0]),
        .data    (wr_data),
        .at_key1 (at_key1),
        .at_key2 (at_key2),
        .dhit    (dhit)
    );

    fcd_id_code #(
        .DATA_W   (DATA_W),
        .TOP_BOOT (TOP_BOOT)
    ) idcode_i (
        .sel  (rd_a0),
        .code (id_byte)
    );

    assign accept = wr_valid & ~busy;
    assign k1_cyc = at_key1 & dhit[C_KEY1];
    assign k2_cyc = at_key2 & dhit[C_KEY2];

    always_comb begin
        st_d       = st_q;
        st_d.prog  = 1'b0;
        st_d.erase = 1'b0;
        st_d.lock  = 1'b0;
        st_d.enter = 1'b0;
        st_d.leave = 1'b0;
        if (accept) begin
            st_d.st = ST_IDLE;
            if (st_q.st == ST_PROG) begin
                st_d.prog  = 1'b1;
                st_d.paddr = wr_addr;
                st_d.pdata = wr_data;
            end else if (dhit[C_IDOUT]) begin
                st_d.leave   = 1'b1;
                st_d.id_mode = 1'b0;
            end else begin
                case (st_q.st)
                    ST_IDLE: if (k1_cyc) st_d.st = ST_UNL1;
                    ST_UNL1: if (k2_cyc) st_d.st = ST_UNL2;
                    ST_UNL2: begin
                        if (at_key1 && dhit[C_PROG]) begin
                            st_d.st = ST_PROG;
                        end else if (at_key1 && dhit[C_PRE]) begin
                            st_d.st = ST_ERA1;
                        end else if (at_key1 && dhit[C_IDIN]) begin
                            st_d.enter   = 1'b1;
                            st_d.id_mode = 1'b1;
                        end
                    end
                    ST_ERA1: if (k1_cyc) st_d.st = ST_ERA2;
                    ST_ERA2: if (k2_cyc) st_d.st = ST_ERA3;
                    ST_ERA3: begin
                        if (at_key1 && dhit[C_ERASE]) begin
                            st_d.erase = 1'b1;
                        end else if (at_key1 && dhit[C_LOCK]) begin
                            st_d.lock = 1'b1;
                        end
                    end
                    default: st_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, paddr: '0, pdata: '0, default: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign prog_pulse     = st_q.prog;
    assign prog_addr      = st_q.paddr;
    assign prog_data      = st_q.pdata;
    assign erase_pulse    = st_q.erase;
    assign lock_pulse     = st_q.lock;
    assign id_enter_pulse = st_q.enter;
    assign id_exit_pulse  = st_q.leave;
    assign id_mode        = st_q.id_mode;
    assign pulse_vec      = {st_q.prog, st_q.erase, st_q.lock, st_q.enter, st_q.leave};

    // R10: the command pulses are mutually exclusive
    a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_vec));

    // R9: a masked write neither pulses nor moves the sequence
    a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (pulse_vec == '0) && $stable(st_q.st) && $stable(id_mode));

    // R8: no write, no change
    a_r8_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> (pulse_vec == '0) && $stable(id_mode));

    // R5: entry pulse coincides with the flag being set
    a_r5_enter_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
        id_enter_pulse |-> id_mode);

    // R6: exit pulse coincides with the flag being clear
    a_r6_exit_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
        id_exit_pulse |-> !id_mode);

    // R12: latched program fields only move with a program pulse
    a_r12_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_pulse |-> $stable(prog_addr) && $stable(prog_data));

endmodule

// File: tb/fcd_cmd_decoder_tb.sv
module fcd_cmd_decoder_tb_top;

    localparam int AW = 20;
    localparam int DW = 8;

    localparam int M_IDLE = 0;
    localparam int M_K1   = 1;
    localparam int M_K2   = 2;
    localparam int M_PROG = 3;
    localparam int M_E1   = 4;
    localparam int M_E2   = 5;
    localparam int M_E3   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy = 1'b0;
    logic          rd_a0 = 1'b0;
    logic          prog_pulse, erase_pulse, lock_pulse;
    logic          id_enter_pulse, id_exit_pulse, id_mode;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data, id_byte;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int            ms = M_IDLE;
    logic          e_prog, e_erase, e_lock, e_ent, e_exit, e_idm;
    logic [AW-1:0] e_pa;
    logic [DW-1:0] e_pd;

    always #2 clk = ~clk;

    fcd_cmd_decoder #(
        .ADDR_W   (AW),
        .DATA_W   (DW),
        .CMP_W    (15),
        .TOP_BOOT (1'b1)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_valid       (wr_valid),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .busy           (busy),
        .rd_a0          (rd_a0),
        .prog_pulse     (prog_pulse),
        .prog_addr      (prog_addr),
        .prog_data      (prog_data),
        .erase_pulse    (erase_pulse),
        .lock_pulse     (lock_pulse),
        .id_enter_pulse (id_enter_pulse),
        .id_exit_pulse  (id_exit_pulse),
        .id_mode        (id_mode),
        .id_byte        (id_byte)
    );

    function automatic logic is_k1(input logic [AW-1:0] a);
        return a[14:0] == 15'h5555;
    endfunction

    function automatic logic is_k2(input logic [AW-1:0] a);
        return a[14:0] == 15'h2AAA;
    endfunction

    task automatic model(input logic acc, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int nx;
        e_prog = 0; e_erase = 0; e_lock = 0; e_ent = 0; e_exit = 0;
        if (!acc) return;
        if (ms == M_PROG) begin
            e_prog = 1; e_pa = a; e_pd = d; ms = M_IDLE;
            return;
        end
        if (d == 8'hF0) begin
            e_exit = 1; e_idm = 0; ms = M_IDLE;
            return;
        end
        nx = M_IDLE;
        case (ms)
            M_IDLE: if (is_k1(a) && d == 8'hAA) nx = M_K1;
            M_K1:   if (is_k2(a) && d == 8'h55) nx = M_K2;
            M_K2: if (is_k1(a)) begin
                if (d == 8'hA0) nx = M_PROG;
                else if (d == 8'h80) nx = M_E1;
                else if (d == 8'h90) begin e_ent = 1; e_idm = 1; end
            end
            M_E1:   if (is_k1(a) && d == 8'hAA) nx = M_E2;
            M_E2:   if (is_k2(a) && d == 8'h55) nx = M_E3;
            M_E3: if (is_k1(a)) begin
                if (d == 8'h10) e_erase = 1;
                else if (d == 8'h40) e_lock = 1;
            end
            default: nx = M_IDLE;
        endcase
        ms = nx;
    endtask

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "prog_pulse", 32'(prog_pulse), 32'(e_prog));
        cmp(tag, "erase_pulse", 32'(erase_pulse), 32'(e_erase));
        cmp(tag, "lock_pulse", 32'(lock_pulse), 32'(e_lock));
        cmp(tag, "id_enter_pulse", 32'(id_enter_pulse), 32'(e_ent));
        cmp(tag, "id_exit_pulse", 32'(id_exit_pulse), 32'(e_exit));
        cmp(tag, "id_mode", 32'(id_mode), 32'(e_idm));
        cmp("R12", "prog_addr", 32'(prog_addr), 32'(e_pa));
        cmp("R12", "prog_data", 32'(prog_data), 32'(e_pd));
        cmp("R10", "pulse count",
            32'(int'(prog_pulse) + int'(erase_pulse) + int'(lock_pulse) + int'(id_enter_pulse) + int'(id_exit_pulse)) <= 1 ? 32'd1 : 32'd0,
            32'd1);
    endtask

    task automatic cyc(input string tag, input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic b);
        @(negedge clk);
        wr_valid = v; wr_addr = a; wr_data = d; busy = b;
        model(v && !b, a, d);
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    task automatic wr(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
        cyc(tag, 1'b1, a, d, 1'b0);
    endtask

    task automatic unlock(input string tag);
        wr(tag, 20'h05555, 8'hAA);
        wr(tag, 20'h02AAA, 8'h55);
    endtask

    task automatic check_id(input logic sel, input logic [DW-1:0] exp);
        @(negedge clk);
        rd_a0 = sel;
        #1;
        cmp("R11", "id_byte", 32'(id_byte), 32'(exp));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        e_prog = 0; e_erase = 0; e_lock = 0; e_ent = 0; e_exit = 0; e_idm = 0;
        e_pa = '0; e_pd = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc("R1", 1'b0, '0, '0, 1'b0);

        // R2 program with full address
        unlock("R2");
        wr("R2", 20'h05555, 8'hA0);
        wr("R2", 20'hA1234, 8'h3C);
        cmp("R2", "prog_pulse seen", 32'(prog_pulse), 32'd1);
        // R2 data 0xF0 is program data, not an exit
        unlock("R2");
        wr("R2", 20'h05555, 8'hA0);
        wr("R2", 20'h00777, 8'hF0);
        // R12 hold over idle clocks and other commands
        repeat (3) cyc("R12", 1'b0, 20'hFFFFF, 8'hFF, 1'b0);

        // R3 erase
        unlock("R3");
        wr("R3", 20'h05555, 8'h80);
        unlock("R3");
        wr("R3", 20'h05555, 8'h10);
        cmp("R3", "erase seen", 32'(erase_pulse), 32'd1);

        // R4 lockout
        unlock("R4");
        wr("R4", 20'h05555, 8'h80);
        unlock("R4");
        wr("R4", 20'h05555, 8'h40);
        cmp("R4", "lock seen", 32'(lock_pulse), 32'd1);

        // R5 entry, R11 identification bytes
        unlock("R5");
        wr("R5", 20'h05555, 8'h90);
        cmp("R5", "id_mode set", 32'(id_mode), 32'd1);
        check_id(1'b0, 8'h1F);
        check_id(1'b1, 8'h27);

        // R6 three-cycle exit
        unlock("R6");
        wr("R6", 20'h05555, 8'hF0);
        cmp("R6", "id_mode clear", 32'(id_mode), 32'd0);
        // R6 lone exit to arbitrary address from mid-sequence
        unlock("R6");
        wr("R6", 20'h05555, 8'h90);
        wr("R6", 20'h05555, 8'hAA);
        wr("R6", 20'hFFFFF, 8'hF0);
        cmp("R6", "lone exit", 32'(id_mode), 32'd0);

        // R7 upper address bits ignored
        wr("R7", 20'h75555, 8'hAA);
        wr("R7", 20'hFAAAA, 8'h55);
        wr("R7", 20'hD5555, 8'hA0);
        wr("R7", 20'hC0001, 8'h5A);
        cmp("R7", "masked prog", 32'(prog_pulse), 32'd1);
        // R7 a low-bit difference breaks the match
        wr("R7", 20'h05554, 8'hAA);
        wr("R7", 20'h02AAA, 8'h55);
        wr("R7", 20'h05555, 8'hA0);
        wr("R7", 20'h00010, 8'h11);
        cmp("R7", "no prog", 32'(prog_pulse), 32'd0);

        // R8 abort; the breaking cycle starts nothing
        wr("R8", 20'h05555, 8'hAA);
        wr("R8", 20'h02AAB, 8'h55);
        wr("R8", 20'h02AAA, 8'h55);
        wr("R8", 20'h05555, 8'hA0);
        wr("R8", 20'h00020, 8'h12);
        cmp("R8", "no prog", 32'(prog_pulse), 32'd0);
        wr("R8", 20'h05555, 8'hAA);
        wr("R8", 20'h05555, 8'hAA);
        wr("R8", 20'h02AAA, 8'h55);
        wr("R8", 20'h05555, 8'h90);
        cmp("R8", "no entry", 32'(id_mode), 32'd0);

        // R9 busy cycles are invisible
        wr("R9", 20'h05555, 8'hAA);
        cyc("R9", 1'b1, 20'h00000, 8'h12, 1'b1);
        cyc("R9", 1'b1, 20'h00000, 8'hF0, 1'b1);
        wr("R9", 20'h02AAA, 8'h55);
        wr("R9", 20'h05555, 8'hA0);
        cyc("R9", 1'b1, 20'h00099, 8'h77, 1'b1);
        wr("R9", 20'h00042, 8'h66);
        cmp("R9", "prog after busy", 32'(prog_pulse), 32'd1);

        // R10 and all others: weighted random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            int k;
            a = AW'($urandom);
            d = DW'($urandom);
            k = int'($urandom % 12);
            case (k)
                0, 1, 2: begin a[14:0] = 15'h5555; d = 8'hAA; end
                3, 4, 5: begin a[14:0] = 15'h2AAA; d = 8'h55; end
                6:       begin a[14:0] = 15'h5555; d = 8'hA0; end
                7:       begin a[14:0] = 15'h5555; d = 8'h80; end
                8:       begin a[14:0] = 15'h5555; d = 8'h90; end
                9:       begin a[14:0] = 15'h5555; d = ($urandom % 2) ? 8'h10 : 8'h40; end
                10:      d = 8'hF0;
                default: ;
            endcase
            cyc("R10", ($urandom % 100) < 85, a, d, ($urandom % 100) < 10);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule